// File: doc/BRIEF.md
# Word Queue with Selectable Interrupt Source

This block is a single circular queue of data words with one write port and one read port. Each port moves one word per clock. The storage ring is internal. A size code picks the ring length, and two threshold codes place the nearly-empty and nearly-full marks. A four-bit level status, two sticky error flags and one interrupt line show the state of the queue to the logic that serves it.

The interrupt is raised by one of eight conditions, chosen by a three-bit source code. Each condition belongs to a kind of access (read or write) and is tested on the queue state that results from that access. Only a completed access can raise it: a read refused because the queue is empty, or a write refused because it is full, never does. Once raised, the interrupt flag stays set until a one-cycle clear pulse arrives. The output line is that flag ANDed with an enable input.

Top module: `sel_irq_queue`

## Requirements
- R1: After reset, `qStatus` reads 4'h3 (empty and nearly empty) when the nearly-full mark lies below the ring size. `underflow`, `overflow` and `irq` read 0.
- R2: Words come out in the order they went in. The ring length is 16, 32, 64 or 128 words for `cfgSize` 0, 1, 2 or 3. The order holds across pointer wrap-around. Read data is registered and shows in the cycle after the read.
- R3: `qStatus` bit 0 (empty) is set exactly when the fill level is 0. Bit 3 (full) is set exactly when the fill level equals the ring length.
- R4: `qStatus` bit 1 (nearly empty) is set exactly when the fill level is at most 2^`cfgNeThr`.
- R5: `qStatus` bit 2 (nearly full) is set exactly when the free space (ring length minus fill level) is at most 2^`cfgNfThr`.
- R6: A read of an empty queue returns 0 and leaves the fill level unchanged. It sets `underflow`, which then stays set until reset.
- R7: A write to a full queue discards the word and leaves the fill level unchanged. It sets `overflow`, which then stays set until reset.
- R8: `cfgSrcSel` picks the interrupt condition, tested on the state after a completed access. The codes are: 0 = empty after a read, 1 = nearly empty after a read, 2 = nearly full after a write, 3 = full after a write, 4 = not empty after a write, 5 = not nearly empty after a write, 6 = not nearly full after a read, 7 = not full after a read.
- R9: The interrupt flag stays set until an `intClear` pulse. When a new trigger and a clear fall in the same cycle, the flag stays set. `irq` is the flag ANDed with `intEnable`, so a flag raised while the enable is low appears once the enable goes high.
- R10: A read and a write in the same cycle on a queue that is neither empty nor full both complete, and the fill level stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write one word this cycle |
| wrData | input | 32 | Word to write |
| rdEn | input | 1 | Read one word this cycle |
| rdData | output | 32 | Word read, valid the cycle after `rdEn` (0 on underflow) |
| cfgSize | input | 2 | Ring length code: 16 << code words |
| cfgNeThr | input | 3 | Nearly-empty mark code n, level <= 2^n |
| cfgNfThr | input | 3 | Nearly-full mark code n, free space <= 2^n |
| cfgSrcSel | input | 3 | Interrupt source code |
| intEnable | input | 1 | Gates the interrupt flag onto `irq` |
| intClear | input | 1 | One-cycle pulse that clears the interrupt flag |
| qStatus | output | 4 | {full, nearly full, nearly empty, empty} |
| underflow | output | 1 | Sticky: a read hit an empty queue |
| overflow | output | 1 | Sticky: a write hit a full queue |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `cfgSize` stays constant while the queue holds data. A size change on a non-empty ring would break the bound on the fill level and the pointer-hold relations. The thresholds and the source code may change at any time, because they only reshape combinational decodes. The stimulus writes the size only while reset is asserted and sets each new configuration before it releases reset. Between releases it changes only the enable and clear inputs, and the accesses it drives always run against a ring whose length is fixed.

// File: rtl/selq_pkg.sv
package selq_pkg;
  // Strobes from control to datapath: a completed access of each kind.
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

  // Level status, packed so that bit 0 is empty and bit 3 is full.
  typedef struct packed {
    logic full;
    logic nearFull;
    logic nearEmpty;
    logic empty;
  } qStat_t;

  typedef enum logic [2:0] {
    SRC_EMPTY_AFTER_RD     = 3'd0,
    SRC_NEMPTY_AFTER_RD    = 3'd1,
    SRC_NFULL_AFTER_WR     = 3'd2,
    SRC_FULL_AFTER_WR      = 3'd3,
    SRC_NOTEMPTY_AFTER_WR  = 3'd4,
    SRC_NOTNEMPTY_AFTER_WR = 3'd5,
    SRC_NOTNFULL_AFTER_RD  = 3'd6,
    SRC_NOTFULL_AFTER_RD   = 3'd7
  } irqSrc_t;
endpackage

// File: rtl/selq_datapath.sv
module selq_datapath
  import selq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PTR_W      = 7,
  parameter int SIZE_SEL_W = 2,
  parameter int MIN_LOG2   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  qStrobe_t              strobe,
  input  logic                  rdEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [SIZE_SEL_W-1:0] cfgSize,
  output logic [DATA_W-1:0]     rdData,
  output logic [PTR_W:0]        wrPtr,
  output logic [PTR_W:0]        rdPtr
);
  localparam int DEPTH_MAX = 1 << PTR_W;
  localparam int PW        = PTR_W + 1;   // pointer plus wrap bit
  localparam int LW        = PW + 1;      // room for twice the depth

  logic [LW-1:0]     depth;
  logic [PW-1:0]     ptrMask;
  logic [PTR_W-1:0]  idxMask;
  logic [PTR_W-1:0]  wrIdx;
  logic [PTR_W-1:0]  rdIdx;
  logic [DATA_W-1:0] ring [DEPTH_MAX];

  always_comb begin
    depth   = LW'(1) << (MIN_LOG2 + int'(cfgSize));
    ptrMask = PW'((depth << 1) - LW'(1));
    idxMask = PTR_W'(depth - LW'(1));
    wrIdx   = wrPtr[PTR_W-1:0] & idxMask;
    rdIdx   = rdPtr[PTR_W-1:0] & idxMask;
  end

  // Pointers advance modulo twice the selected depth.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr + PW'(1)) & ptrMask;
      if (strobe.pop)  rdPtr <= (rdPtr + PW'(1)) & ptrMask;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) ring[wrIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= strobe.pop ? ring[rdIdx] : '0;
  end

  // R2: without a completed access neither pointer moves.
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.push && !strobe.pop) |=> ($stable(wrPtr) && $stable(rdPtr)));

  // R3: the fill level never exceeds the selected depth.
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (LW'((wrPtr - rdPtr) & ptrMask) <= depth));

  // R6: a refused read returns zero in the next cycle.
  p_zero_on_refused_rd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !strobe.pop) |=> (rdData == '0));
endmodule

// File: rtl/selq_ctrl.sv
module selq_ctrl
  import selq_pkg::*;
#(
  parameter int PTR_W      = 7,
  parameter int SIZE_SEL_W = 2,
  parameter int THR_W      = 3,
  parameter int MIN_LOG2   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [PTR_W:0]        wrPtr,
  input  logic [PTR_W:0]        rdPtr,
  input  logic [SIZE_SEL_W-1:0] cfgSize,
  input  logic [THR_W-1:0]      cfgNeThr,
  input  logic [THR_W-1:0]      cfgNfThr,
  input  logic [2:0]            cfgSrcSel,
  input  logic                  intEnable,
  input  logic                  intClear,
  output qStrobe_t              strobe,
  output qStat_t                status,
  output logic                  underflow,
  output logic                  overflow,
  output logic                  irq
);
  localparam int PW = PTR_W + 1;
  localparam int LW = PW + 1;

  logic [LW-1:0] depth;
  logic [PW-1:0] ptrMask;
  logic [LW-1:0] level;
  logic [LW-1:0] nextLevel;
  logic [LW-1:0] neLimit;
  logic [LW-1:0] nfLimit;
  qStat_t        nextStat;
  irqSrc_t       srcSel;
  logic          trigger;
  logic          intFlag;

  function automatic qStat_t levelToStat(input logic [LW-1:0] lvl,
                                         input logic [LW-1:0] dep,
                                         input logic [LW-1:0] neLim,
                                         input logic [LW-1:0] nfLim);
    qStat_t s;
    s.empty     = (lvl == '0);
    s.nearEmpty = (lvl <= neLim);
    s.nearFull  = ((dep - lvl) <= nfLim);
    s.full      = (lvl == dep);
    return s;
  endfunction

  always_comb begin
    depth   = LW'(1) << (MIN_LOG2 + int'(cfgSize));
    ptrMask = PW'((depth << 1) - LW'(1));
    level   = LW'((wrPtr - rdPtr) & ptrMask);
    neLimit = LW'(1) << cfgNeThr;
    nfLimit = LW'(1) << cfgNfThr;
    status  = levelToStat(level, depth, neLimit, nfLimit);

    // Each access is judged on the state before the edge.
    strobe.push = wrEn && !status.full;
    strobe.pop  = rdEn && !status.empty;

    nextLevel = level + LW'(strobe.push) - LW'(strobe.pop);
    nextStat  = levelToStat(nextLevel, depth, neLimit, nfLimit);
  end

  // Source decode: the condition on the post-access state, qualified by
  // a completed access of the matching kind.
  always_comb begin
    srcSel = irqSrc_t'(cfgSrcSel);
    unique case (srcSel)
      SRC_EMPTY_AFTER_RD:     trigger = strobe.pop  &&  nextStat.empty;
      SRC_NEMPTY_AFTER_RD:    trigger = strobe.pop  &&  nextStat.nearEmpty;
      SRC_NFULL_AFTER_WR:     trigger = strobe.push &&  nextStat.nearFull;
      SRC_FULL_AFTER_WR:      trigger = strobe.push &&  nextStat.full;
      SRC_NOTEMPTY_AFTER_WR:  trigger = strobe.push && !nextStat.empty;
      SRC_NOTNEMPTY_AFTER_WR: trigger = strobe.push && !nextStat.nearEmpty;
      SRC_NOTNFULL_AFTER_RD:  trigger = strobe.pop  && !nextStat.nearFull;
      SRC_NOTFULL_AFTER_RD:   trigger = strobe.pop  && !nextStat.full;
      default:                trigger = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underflow <= 1'b0;
      overflow  <= 1'b0;
      intFlag   <= 1'b0;
    end else begin
      if (rdEn && status.empty) underflow <= 1'b1;
      if (wrEn && status.full)  overflow  <= 1'b1;
      if (trigger)              intFlag   <= 1'b1;
      else if (intClear)        intFlag   <= 1'b0;
    end
  end

  assign irq = intFlag && intEnable;

  // R6: underflow, once raised, stays raised.
  p_underflow_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);

  // R7: overflow rises only after a write met a full queue.
  p_overflow_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(wrEn && status.full));

  // R7: overflow, once raised, stays raised.
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9: without a clear the flag holds.
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !intClear) |=> intFlag);

  // R8: the flag rises only in the cycle after a completed access.
  p_irq_needs_access_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> $past(strobe.push || strobe.pop));

  // R3/R4: empty and full exclude each other; empty implies nearly empty.
  p_empty_full_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(status.empty && status.full));
  p_empty_is_near_r4: assert property (@(posedge clk) disable iff (!rstN)
    status.empty |-> status.nearEmpty);
endmodule

// File: rtl/sel_irq_queue.sv
module sel_irq_queue
  import selq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PTR_W      = 7,
  parameter int SIZE_SEL_W = 2,
  parameter int THR_W      = 3,
  parameter int MIN_LOG2   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  rdEn,
  output logic [DATA_W-1:0]     rdData,
  input  logic [SIZE_SEL_W-1:0] cfgSize,
  input  logic [THR_W-1:0]      cfgNeThr,
  input  logic [THR_W-1:0]      cfgNfThr,
  input  logic [2:0]            cfgSrcSel,
  input  logic                  intEnable,
  input  logic                  intClear,
  output logic [3:0]            qStatus,
  output logic                  underflow,
  output logic                  overflow,
  output logic                  irq
);
  qStrobe_t       strobe;
  qStat_t         status;
  logic [PTR_W:0] wrPtr;
  logic [PTR_W:0] rdPtr;

  selq_ctrl #(
    .PTR_W(PTR_W), .SIZE_SEL_W(SIZE_SEL_W), .THR_W(THR_W), .MIN_LOG2(MIN_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .cfgSize(cfgSize),
    .cfgNeThr(cfgNeThr), .cfgNfThr(cfgNfThr), .cfgSrcSel(cfgSrcSel),
    .intEnable(intEnable), .intClear(intClear),
    .strobe(strobe), .status(status),
    .underflow(underflow), .overflow(overflow), .irq(irq)
  );

  selq_datapath #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .SIZE_SEL_W(SIZE_SEL_W), .MIN_LOG2(MIN_LOG2)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdEn(rdEn),
    .wrData(wrData), .cfgSize(cfgSize),
    .rdData(rdData), .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  assign qStatus = status;
endmodule

// File: tb/sel_irq_queue_bench.sv
module sel_irq_queue_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [1:0]  cfgSize = '0;
  logic [2:0]  cfgNeThr = '0;
  logic [2:0]  cfgNfThr = '0;
  logic [2:0]  cfgSrcSel = '0;
  logic        intEnable = 1'b0;
  logic        intClear = 1'b0;
  logic [3:0]  qStatus;
  logic        underflow;
  logic        overflow;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int mLevel;
  int mDepth;
  logic [31:0] mRing[$];
  logic [31:0] seed = 32'hA5000000;
  logic mFlag;

  always #5 clk = ~clk;

  sel_irq_queue u_sel_irq_queue (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .cfgSize(cfgSize), .cfgNeThr(cfgNeThr),
    .cfgNfThr(cfgNfThr), .cfgSrcSel(cfgSrcSel), .intEnable(intEnable),
    .intClear(intClear), .qStatus(qStatus), .underflow(underflow),
    .overflow(overflow), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expStat(input int lvl);
    logic [3:0] s;
    s[0] = (lvl == 0);
    s[1] = (lvl <= (1 << cfgNeThr));
    s[2] = ((mDepth - lvl) <= (1 << cfgNfThr));
    s[3] = (lvl == mDepth);
    return s;
  endfunction

  // Reset with a configuration already in place; leaves the bench at a negedge.
  task automatic doReset(input logic [1:0] sz, input logic [2:0] ne,
                         input logic [2:0] nf, input logic [2:0] sel);
    @(negedge clk);
    rstN = 1'b0;
    cfgSize = sz; cfgNeThr = ne; cfgNfThr = nf; cfgSrcSel = sel;
    @(negedge clk);
    rstN = 1'b1;
    mDepth = 16 << sz;
    mLevel = 0;
    mRing.delete();
    mFlag = 1'b0;
  endtask

  // One access cycle; the model advances and outputs are sampled after the edge.
  task automatic op(input logic rd, input logic wr, input logic clr, input string req);
    logic popOk, pushOk, hit;
    logic [31:0] expRd;
    logic [3:0] ns;
    popOk  = rd && (mLevel > 0);
    pushOk = wr && (mLevel < mDepth);
    expRd  = '0;
    rdEn = rd; wrEn = wr; intClear = clr; wrData = seed;
    if (popOk) expRd = mRing.pop_front();
    if (pushOk) mRing.push_back(seed);
    mLevel = mLevel + int'(pushOk) - int'(popOk);
    ns = expStat(mLevel);
    case (cfgSrcSel)
      3'd0: hit = popOk && ns[0];
      3'd1: hit = popOk && ns[1];
      3'd2: hit = pushOk && ns[2];
      3'd3: hit = pushOk && ns[3];
      3'd4: hit = pushOk && !ns[0];
      3'd5: hit = pushOk && !ns[1];
      3'd6: hit = popOk && !ns[2];
      default: hit = popOk && !ns[3];
    endcase
    if (hit) mFlag = 1'b1;
    else if (clr) mFlag = 1'b0;
    seed = seed + 32'd1;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; intClear = 1'b0;
    if (rd) check({req, " R2 read data"}, rdData, expRd);
    check({req, " R3/R4/R5 status"}, {28'd0, qStatus}, {28'd0, ns});
  endtask

  initial begin
    // R1: reset state
    doReset(2'd0, 3'd0, 3'd0, 3'd0);
    check("R1 status", {28'd0, qStatus}, 32'h3);
    check("R1 underflow", {31'd0, underflow}, 32'd0);
    check("R1 overflow", {31'd0, overflow}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // Sweep every size with two threshold settings.
    for (int sz = 0; sz < 4; sz++) begin
      for (int tp = 0; tp < 2; tp++) begin
        doReset(2'(sz), tp == 0 ? 3'd0 : 3'(sz + 2), tp == 0 ? 3'd1 : 3'd3, 3'd0);
        for (int i = 0; i < mDepth; i++) op(1'b0, 1'b1, 1'b0, "fill");
        check("R3 full after fill", {31'd0, qStatus[3]}, 32'd1);
        op(1'b0, 1'b1, 1'b0, "R7 write to full");
        check("R7 overflow", {31'd0, overflow}, 32'd1);
        check("R7 level kept", {31'd0, qStatus[3]}, 32'd1);
        for (int i = 0; i < mDepth; i++) op(1'b1, 1'b0, 1'b0, "drain");
        op(1'b1, 1'b0, 1'b0, "R6 read of empty");
        check("R6 zero data", rdData, 32'd0);
        check("R6 underflow", {31'd0, underflow}, 32'd1);
        check("R7 overflow still set", {31'd0, overflow}, 32'd1);
        // R2: wrap-around with pointers offset by half the ring.
        for (int i = 0; i < mDepth / 2 + 3; i++) op(1'b0, 1'b1, 1'b0, "R2 prefill");
        for (int i = 0; i < 5; i++) op(1'b1, 1'b1, 1'b0, "R10 both");
        for (int i = 0; i < mDepth / 2 - 3; i++) op(1'b0, 1'b1, 1'b0, "R2 wrap fill");
        for (int i = 0; i < mDepth; i++) op(1'b1, 1'b0, 1'b0, "R2 wrap drain");
        check("R6 underflow sticky", {31'd0, underflow}, 32'd1);
      end
    end

    // R8/R9: every source code over one mixed access sequence.
    for (int sel = 0; sel < 8; sel++) begin
      doReset(2'd0, 3'd1, 3'd1, 3'(sel));
      intEnable = 1'b1;
      for (int i = 0; i < 48; i++) begin
        logic rd, wr, clr;
        wr  = (i < 18) || (i >= 36);
        rd  = (i >= 18 && i < 36) || (i >= 36 && i % 2 == 1);
        clr = (i % 5 == 4);
        op(rd, wr, clr, "R8 source");
        check($sformatf("R8/R9 irq sel=%0d step=%0d", sel, i), {31'd0, irq}, {31'd0, mFlag});
      end
    end

    // R9: flag raised with the enable low shows up once enabled.
    doReset(2'd0, 3'd1, 3'd1, 3'd4);
    intEnable = 1'b0;
    op(1'b0, 1'b1, 1'b0, "R9 masked trigger");
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    intEnable = 1'b1;
    #1;
    check("R9 irq after enable", {31'd0, irq}, 32'd1);
    op(1'b0, 1'b1, 1'b1, "R9 trigger with clear");
    check("R9 set wins over clear", {31'd0, irq}, 32'd1);
    op(1'b0, 1'b0, 1'b1, "R9 clear");
    check("R9 cleared", {31'd0, irq}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule